// File: doc/BRIEF.md
# Half-Bridge Gate Control Logic

This block is the digital decision core for a single inverter half-bridge leg. It receives an active-high command for the upper switch and one for the lower switch, the sampled level of a shared active-low shutdown pin, a flag from an overcurrent comparator and a flag that says the gate supply is healthy. From these it produces the two gate enables and an enable for an open-drain transistor that can pull the shared shutdown pin low.

The commands and the shutdown pin pass through two-flop synchronizers. The leg is never allowed to conduct through both switches at once. A programmable dead time always separates one gate turning off from the other turning on.

The overcurrent flag takes a short path that skips the synchronizers, so both gates drop on the next clock edge. The same flag arms a latch that pulls the shutdown pin low. The latch holds until the synchronized pin level reads low, so the disable time lasts at least as long as the external network takes to discharge.

Top module: `hb_gate_ctrl`

## Requirements
- R1: While the synchronized shutdown level is low (0), both gate enables are 0, whatever the commands are.
- R2: While both commands are 1, both gate enables settle to 0 (interlock).
- R3: With shutdown high and supply healthy, commands 0/0 give both gates 0. Upper command alone gives hi_gate=1 and lo_gate=0. Lower command alone gives lo_gate=1 and hi_gate=0.
- R4: hi_gate and lo_gate are never 1 in the same cycle.
- R5: Before either gate turns on, both gates have been 0 for at least DEAD_CYC consecutive cycles. This holds after reset, after a fault and after a supply dip.
- R6: An overcurrent flag sampled 1 at a clock edge forces both gates to 0 from that edge on.
- R7: An overcurrent flag sampled 1 sets sd_pull at that edge. sd_pull stays 1 until a synchronized pin level of 0 is seen with the flag low, and it then releases.
- R8: A shutdown pin falling to 0 turns off an active gate within three clock edges (two synchronizer stages plus the output register).
- R9: A supply_ok of 0 sampled at an edge forces both gates to 0 from that edge on. Operation then resumes from the current commands under the dead-time rule of R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock (100 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_cmd | input | 1 | Upper switch command, active high |
| lo_cmd | input | 1 | Lower switch command, active high |
| sd_pin_n | input | 1 | Level read back from the shared shutdown pin, 0 means shutdown |
| oc_flag | input | 1 | Overcurrent comparator output, active high |
| supply_ok | input | 1 | Gate supply healthy, 0 means undervoltage lockout |
| hi_gate | output | 1 | Upper gate enable |
| lo_gate | output | 1 | Lower gate enable |
| sd_pull | output | 1 | Enable of the open-drain pulldown on the shutdown pin |

## Verification
The two functions that can fall in the same cycle are the end of a dead-time count, at which a gate would turn on, and an overcurrent trip, which must keep it off. The bench switches the leg from the lower gate to the upper gate and then raises the overcurrent flag after every delay from zero to a few cycles past the dead time, so one sweep point lands on the exact edge where the upper gate would rise. At each point the upper gate must be 0 after the trip edge and the pulldown must be asserted. A running both-low counter confirms that the later recovery still waits out the full dead time.

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl #(
  parameter int DEAD_CYC    = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hi_cmd,
  input  logic lo_cmd,
  input  logic sd_pin_n,
  input  logic oc_flag,
  input  logic supply_ok,
  output logic hi_gate,
  output logic lo_gate,
  output logic sd_pull
);
  localparam int CW = $clog2(DEAD_CYC + 1);
  localparam logic [CW-1:0] DEAD_LD = CW'(DEAD_CYC);

  typedef enum logic [1:0] {W_OFF, W_HI, W_LO} want_t;

  logic [SYNC_STAGES-1:0] hi_sy, lo_sy, sd_sy;
  logic [CW-1:0] cnt;
  logic hi_q, lo_q, pull_q;
  logic hi_s, lo_s, sd_s, kill;
  want_t want;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hi_sy <= '0;
      lo_sy <= '0;
      sd_sy <= '0;
    end else begin
      hi_sy <= {hi_sy[SYNC_STAGES-2:0], hi_cmd};
      lo_sy <= {lo_sy[SYNC_STAGES-2:0], lo_cmd};
      sd_sy <= {sd_sy[SYNC_STAGES-2:0], sd_pin_n};
    end

  assign hi_s = hi_sy[SYNC_STAGES-1];
  assign lo_s = lo_sy[SYNC_STAGES-1];
  assign sd_s = sd_sy[SYNC_STAGES-1];
  assign kill = oc_flag | pull_q | ~sd_s | ~supply_ok;

  always_comb begin
    if (kill || (hi_s == lo_s)) want = W_OFF;
    else if (hi_s)              want = W_HI;
    else                        want = W_LO;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pull_q <= 1'b0;
    else        pull_q <= oc_flag | (pull_q & sd_s);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hi_q <= 1'b0;
      lo_q <= 1'b0;
      cnt  <= DEAD_LD;
    end else begin
      case (want)
        W_HI: begin
          if (lo_q) begin
            lo_q <= 1'b0;
            cnt  <= DEAD_LD;
          end else if (cnt == '0) hi_q <= 1'b1;
          else cnt <= cnt - 1'b1;
        end
        W_LO: begin
          if (hi_q) begin
            hi_q <= 1'b0;
            cnt  <= DEAD_LD;
          end else if (cnt == '0) lo_q <= 1'b1;
          else cnt <= cnt - 1'b1;
        end
        default: begin
          hi_q <= 1'b0;
          lo_q <= 1'b0;
          if (kill || hi_q || lo_q) cnt <= DEAD_LD;
          else if (cnt != '0)       cnt <= cnt - 1'b1;
        end
      endcase
    end

  assign hi_gate = hi_q;
  assign lo_gate = lo_q;
  assign sd_pull = pull_q;
endmodule

// File: rtl/hb_gate_ctrl_chk.sv
module hb_gate_ctrl_chk #(
  parameter int DEAD_CYC = 18
) (
  input logic clk,
  input logic rst_n,
  input logic sd_pin_n,
  input logic oc_flag,
  input logic supply_ok,
  input logic hi_gate,
  input logic lo_gate,
  input logic sd_pull
);
  localparam int RW = $clog2(DEAD_CYC + 2);
  logic [RW-1:0] low_run;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) low_run <= '0;
    else if (hi_gate || lo_gate) low_run <= '0;
    else if (low_run < RW'(DEAD_CYC)) low_run <= low_run + 1'b1;

  AST_NEVER_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_gate && lo_gate)); // R4
  AST_DEAD_GAP_HI: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_gate) |-> low_run >= RW'(DEAD_CYC)); // R5
  AST_DEAD_GAP_LO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lo_gate) |-> low_run >= RW'(DEAD_CYC)); // R5
  AST_OC_KILL: assert property (@(posedge clk) disable iff (!rst_n)
    oc_flag |=> !hi_gate && !lo_gate); // R6
  AST_OC_PULL: assert property (@(posedge clk) disable iff (!rst_n)
    oc_flag |=> sd_pull); // R7
  AST_PULL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sd_pull) |-> !$past(sd_pin_n, 3)); // R7
  AST_UV_KILL: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> !hi_gate && !lo_gate); // R9
endmodule

bind hb_gate_ctrl hb_gate_ctrl_chk #(.DEAD_CYC(DEAD_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .sd_pin_n(sd_pin_n), .oc_flag(oc_flag),
  .supply_ok(supply_ok), .hi_gate(hi_gate), .lo_gate(lo_gate), .sd_pull(sd_pull)
);

// File: tb/hb_gate_ctrl_tb.sv
`timescale 1ns/1ps
module hb_gate_ctrl_tb;
  localparam int DEAD = 18;
  localparam int LAG  = 6;

  logic clk = 0, rst_n = 0;
  logic hi_cmd = 0, lo_cmd = 0, ext_sd = 1, oc_flag = 0, supply_ok = 1;
  logic hi_gate, lo_gate, sd_pull, sd_pin_n;
  logic [LAG-1:0] pull_d = '0;
  int errs = 0, checks = 0, off_run = 0;
  bit done = 0;

  always #10 clk = ~clk;

  always @(posedge clk) pull_d <= {pull_d[LAG-2:0], sd_pull};
  assign sd_pin_n = ext_sd & ~pull_d[LAG-1];

  hb_gate_ctrl #(.DEAD_CYC(DEAD)) u_dut (
    .clk(clk), .rst_n(rst_n), .hi_cmd(hi_cmd), .lo_cmd(lo_cmd),
    .sd_pin_n(sd_pin_n), .oc_flag(oc_flag), .supply_ok(supply_ok),
    .hi_gate(hi_gate), .lo_gate(lo_gate), .sd_pull(sd_pull)
  );

  task automatic chk(input string tag, input logic [2:0] got, input logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got hi/lo/pull=%b expected %b", tag, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_release();
    for (int i = 0; i < 100 && sd_pull; i++) @(negedge clk);
    cyc(DEAD + 10);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if ((hi_gate || lo_gate) && off_run > 0 && off_run < DEAD) begin
        errs++;
        $display("FAIL R5: gate rose after %0d low cycles, expected >= %0d", off_run, DEAD);
      end
      if (hi_gate && lo_gate) begin
        errs++;
        $display("FAIL R4: both gates high got 11 expected not 11");
      end
      off_run = (hi_gate || lo_gate) ? 0 : off_run + 1;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    cyc(3);
    chk("R1 reset", {hi_gate, lo_gate, sd_pull}, 3'b000);
    rst_n = 1;
    cyc(5);
    // R1 R2 R3 R9 sweep of the static truth table
    for (int v = 0; v < 16; v++) begin
      logic h, l, s, o;
      logic [2:0] e;
      {s, o, h, l} = 4'(v);
      hi_cmd = h; lo_cmd = l; ext_sd = s; supply_ok = o;
      cyc(DEAD + 10);
      e = {s & o & h & ~l, s & o & l & ~h, 1'b0};
      chk(!s ? "R1 sd low" : !o ? "R9 uv" : (h & l) ? "R2 interlock" : "R3 direct",
          {hi_gate, lo_gate, sd_pull}, e);
    end
    // R8 pin latency
    hi_cmd = 1; lo_cmd = 0; ext_sd = 1; supply_ok = 1;
    cyc(DEAD + 10);
    chk("R8 pre", {hi_gate, lo_gate, sd_pull}, 3'b100);
    ext_sd = 0;
    cyc(2);
    chk("R8 two edges", {hi_gate, lo_gate, sd_pull}, 3'b100);
    cyc(1);
    chk("R8 three edges", {hi_gate, lo_gate, sd_pull}, 3'b000);
    ext_sd = 1;
    cyc(DEAD + 10);
    // R9 latency
    supply_ok = 0;
    cyc(1);
    chk("R9 one edge", {hi_gate, lo_gate, sd_pull}, 3'b000);
    supply_ok = 1;
    cyc(DEAD + 10);
    chk("R9 resume", {hi_gate, lo_gate, sd_pull}, 3'b100);
    // R6 R7 fault and pulldown hold
    oc_flag = 1;
    cyc(1);
    chk("R6 R7 trip", {hi_gate, lo_gate, sd_pull}, 3'b001);
    oc_flag = 0;
    begin
      int held = 1;
      for (int i = 0; i < 60 && sd_pull; i++) begin
        @(negedge clk);
        if (sd_pull) held++;
      end
      checks++;
      if (held < LAG + 2 || sd_pull) begin
        errs++;
        $display("FAIL R7: pulldown held %0d cycles, expected >= %0d then release", held, LAG + 2);
      end
    end
    cyc(DEAD + 12);
    chk("R7 recover", {hi_gate, lo_gate, sd_pull}, 3'b100);
    // R6 trip collides with end of dead time
    for (int k = 0; k <= DEAD + 4; k++) begin
      hi_cmd = 0; lo_cmd = 1;
      cyc(DEAD + 10);
      hi_cmd = 1; lo_cmd = 0;
      cyc(2 + k);
      oc_flag = 1;
      cyc(1);
      chk($sformatf("R6 collide k=%0d", k), {hi_gate, lo_gate, sd_pull}, 3'b001);
      oc_flag = 0;
      wait_release();
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule